// File: doc/BRIEF.md
# Next-PC and Subroutine Link Unit

This unit picks the program counter that follows a control-transfer instruction in a 16-bit load/store processor. It takes the incremented PC, the instruction word, a base-register value from the register file, and a taken flag from the external condition evaluator. From these it produces the next PC, a request to write the return address into R7, and, for system calls, a read of a handler table that sits in low memory.

Most transfers resolve in one cycle: a PC-relative branch, a subroutine call with a PC-relative or register target, and a register jump, of which a return is the R7 case. A system call takes two steps. The unit issues a one-cycle table-read strobe at the zero-extended vector address and writes the link. It then waits, with `busy` high, until the memory answers. The returned word becomes the next PC.

The sequencer has two states. `S_IDLE` accepts an instruction when `instr_valid` is high. It moves to `S_TRAP_WAIT` on a trap opcode and stays in `S_IDLE` for every other opcode. `S_TRAP_WAIT` returns to `S_IDLE` on the cycle `tt_rvalid` is sampled high, and holds otherwise.

Top module: `npc_link_unit`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `npc_valid`, `link_we`, `tt_req` and `busy` are low, and `npc`, `link_data` and `tt_addr` are zero.
- R2: A branch (opcode bits [15:12] = 0000) accepted with `br_taken` high gives `npc_valid` high in the next cycle, with `npc` = `pc_inc` + sign-extended IR[8:0] modulo 2^16, and no link write.
- R3: A branch accepted with `br_taken` low gives `npc` = `pc_inc` in the next cycle, with no link write.
- R4: A call (opcode 0100) with IR[11] = 1 gives `npc` = `pc_inc` + sign-extended IR[10:0] in the next cycle, together with a one-cycle `link_we` carrying `link_data` = `pc_inc`.
- R5: A call with IR[11] = 0 gives `npc` = `base_val` and a link write of `pc_inc` in the next cycle. `base_val` is sampled when the instruction is accepted, so a call through R7 jumps to the old R7 value.
- R6: A register jump (opcode 1100, which includes return through R7) gives `npc` = `base_val` in the next cycle with no link write. `base_sel` always equals IR[8:6].
- R7: A trap (opcode 1111) gives, in the next cycle, a one-cycle `tt_req` with `tt_addr` = {8'h00, IR[7:0]}, a one-cycle `link_we` with `link_data` = `pc_inc`, and `busy` high.
- R8: While `busy` is high, `npc_valid` stays low until `tt_rvalid` is sampled high. In the next cycle `npc_valid` is high, `npc` equals the sampled `tt_rdata`, and `busy` is low.
- R9: `instr_valid` is ignored while `busy` is high: no `npc_valid`, `link_we` or `tt_req` follows from it. `tt_rvalid` is ignored while not busy.
- R10: Any other opcode accepted gives `npc` = `pc_inc` in the next cycle with no link write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| instr_valid | input | 1 | Instruction present and to be accepted |
| instr | input | 16 | Instruction word |
| pc_inc | input | 16 | Address of the next sequential instruction |
| base_val | input | 16 | Register file read data for `base_sel` |
| br_taken | input | 1 | Branch condition result from the evaluator |
| tt_rdata | input | 16 | Handler table read data |
| tt_rvalid | input | 1 | Handler table read data valid |
| base_sel | output | 3 | Register index to read as base (IR[8:6]) |
| npc_valid | output | 1 | One-cycle strobe: `npc` holds the next PC |
| npc | output | 16 | Next program counter |
| link_we | output | 1 | One-cycle request to write R7 |
| link_data | output | 16 | Return address for R7 |
| tt_req | output | 1 | One-cycle handler table read strobe |
| tt_addr | output | 16 | Handler table read address |
| busy | output | 1 | Trap lookup outstanding |

## Verification
Single-step results (`npc_valid`, `npc`, `link_we`, `link_data`) are due exactly one clock after the edge that accepts the instruction. The trap strobe, its address and the link write are also due one clock after acceptance. The trap's next PC is due one clock after the edge that samples `tt_rvalid`. The bench drives inputs on the falling edge. It runs a behavioural model that updates on the same rising edge as the design, and compares every output 5 ns after each rising edge. This sampling means a result in the wrong cycle shows up as a mismatch. Trap latencies of zero to several cycles, stray instructions during the wait, and stray responses while idle are all exercised.

// File: rtl/npc_pkg.sv
package npc_pkg;

    localparam int OPC_W = 4;

    localparam logic [OPC_W-1:0] OPC_BRANCH = 4'b0000;
    localparam logic [OPC_W-1:0] OPC_CALL   = 4'b0100;
    localparam logic [OPC_W-1:0] OPC_JREG   = 4'b1100;
    localparam logic [OPC_W-1:0] OPC_TRAP   = 4'b1111;

    typedef enum logic [2:0] {
        K_OTHER,
        K_BRANCH,
        K_CALL_REL,
        K_CALL_REG,
        K_JUMP_REG,
        K_TRAP
    } xfer_kind_t;

    typedef enum logic [0:0] {
        S_IDLE,
        S_TRAP_WAIT
    } seq_state_t;

endpackage

// File: rtl/npc_decode.sv
module npc_decode
    import npc_pkg::*;
#(
    parameter int XLEN      = 16,
    parameter int BR_OFF_W  = 9,
    parameter int JS_OFF_W  = 11,
    parameter int VEC_W     = 8,
    parameter int RIDX_W    = 3,
    parameter int MODE_BIT  = 11,
    parameter int BASE_LSB  = 6
) (
    input  logic [XLEN-1:0]   instr,
    output xfer_kind_t        kind,
    output logic [XLEN-1:0]   br_off,
    output logic [XLEN-1:0]   call_off,
    output logic [XLEN-1:0]   vec_addr,
    output logic [RIDX_W-1:0] base_sel
);

    localparam int BR_PAD  = XLEN - BR_OFF_W;
    localparam int JS_PAD  = XLEN - JS_OFF_W;
    localparam int VEC_PAD = XLEN - VEC_W;

    logic [OPC_W-1:0] opc;

    assign opc      = instr[XLEN-1 -: OPC_W];
    assign br_off   = {{BR_PAD{instr[BR_OFF_W-1]}}, instr[BR_OFF_W-1:0]};
    assign call_off = {{JS_PAD{instr[JS_OFF_W-1]}}, instr[JS_OFF_W-1:0]};
    assign vec_addr = {{VEC_PAD{1'b0}}, instr[VEC_W-1:0]};
    assign base_sel = instr[BASE_LSB +: RIDX_W];

    always_comb begin
        unique case (opc)
            OPC_BRANCH: kind = K_BRANCH;
            OPC_CALL:   kind = instr[MODE_BIT] ? K_CALL_REL : K_CALL_REG;
            OPC_JREG:   kind = K_JUMP_REG;
            OPC_TRAP:   kind = K_TRAP;
            default:    kind = K_OTHER;
        endcase
    end

endmodule

// File: rtl/npc_target.sv
module npc_target
    import npc_pkg::*;
#(
    parameter int XLEN = 16
) (
    input  xfer_kind_t      kind,
    input  logic [XLEN-1:0] pc_inc,
    input  logic [XLEN-1:0] base_val,
    input  logic            br_taken,
    input  logic [XLEN-1:0] br_off,
    input  logic [XLEN-1:0] call_off,
    output logic [XLEN-1:0] target,
    output logic            want_link
);

    logic [XLEN-1:0] br_sum;
    logic [XLEN-1:0] call_sum;

    assign br_sum   = pc_inc + br_off;
    assign call_sum = pc_inc + call_off;

    always_comb begin
        target    = pc_inc;
        want_link = 1'b0;
        unique case (kind)
            K_BRANCH:   target = br_taken ? br_sum : pc_inc;
            K_CALL_REL: begin
                target    = call_sum;
                want_link = 1'b1;
            end
            K_CALL_REG: begin
                target    = base_val;
                want_link = 1'b1;
            end
            K_JUMP_REG: target = base_val;
            K_TRAP:     want_link = 1'b1;
            K_OTHER:    target = pc_inc;
            default:    target = pc_inc;
        endcase
    end

endmodule

// File: rtl/npc_seq_fsm.sv
module npc_seq_fsm
    import npc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic instr_valid,
    input  logic is_trap,
    input  logic tt_rvalid,
    output logic accept,
    output logic trap_done,
    output logic busy
);

    seq_state_t state, state_nx;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx  = state;
        accept    = 1'b0;
        trap_done = 1'b0;
        busy      = 1'b0;
        unique case (state)
            S_IDLE: begin
                accept = instr_valid;
                if (instr_valid && is_trap) state_nx = S_TRAP_WAIT;
            end
            S_TRAP_WAIT: begin
                busy      = 1'b1;
                trap_done = tt_rvalid;
                if (tt_rvalid) state_nx = S_IDLE;
            end
            default: state_nx = S_IDLE;
        endcase
    end

    AST_WAIT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !tt_rvalid) |=> busy); // R8
    AST_DONE_LEAVES: assert property (@(posedge clk) disable iff (!rst_n)
        trap_done |=> !busy); // R8

endmodule

// File: rtl/npc_link_unit.sv
module npc_link_unit
    import npc_pkg::*;
#(
    parameter int XLEN     = 16,
    parameter int VEC_W    = 8,
    parameter int RIDX_W   = 3,
    parameter int BR_OFF_W = 9,
    parameter int JS_OFF_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              instr_valid,
    input  logic [XLEN-1:0]   instr,
    input  logic [XLEN-1:0]   pc_inc,
    input  logic [XLEN-1:0]   base_val,
    input  logic              br_taken,
    input  logic [XLEN-1:0]   tt_rdata,
    input  logic              tt_rvalid,
    output logic [RIDX_W-1:0] base_sel,
    output logic              npc_valid,
    output logic [XLEN-1:0]   npc,
    output logic              link_we,
    output logic [XLEN-1:0]   link_data,
    output logic              tt_req,
    output logic [XLEN-1:0]   tt_addr,
    output logic              busy
);

    xfer_kind_t      kind;
    logic [XLEN-1:0] br_off, call_off, vec_addr, target;
    logic            want_link, accept, trap_done, is_trap, fsm_busy;

    npc_decode #(
        .XLEN(XLEN), .BR_OFF_W(BR_OFF_W), .JS_OFF_W(JS_OFF_W),
        .VEC_W(VEC_W), .RIDX_W(RIDX_W), .MODE_BIT(JS_OFF_W), .BASE_LSB(6)
    ) u_dec (
        .instr(instr), .kind(kind), .br_off(br_off), .call_off(call_off),
        .vec_addr(vec_addr), .base_sel(base_sel)
    );

    npc_target #(.XLEN(XLEN)) u_tgt (
        .kind(kind), .pc_inc(pc_inc), .base_val(base_val), .br_taken(br_taken),
        .br_off(br_off), .call_off(call_off), .target(target), .want_link(want_link)
    );

    assign is_trap = (kind == K_TRAP);

    npc_seq_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .is_trap(is_trap),
        .tt_rvalid(tt_rvalid), .accept(accept), .trap_done(trap_done), .busy(fsm_busy)
    );

    assign busy = fsm_busy;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            npc_valid <= 1'b0;
            npc       <= '0;
            link_we   <= 1'b0;
            link_data <= '0;
            tt_req    <= 1'b0;
            tt_addr   <= '0;
        end else begin
            npc_valid <= 1'b0;
            link_we   <= 1'b0;
            tt_req    <= 1'b0;
            if (accept) begin
                if (want_link) begin
                    link_we   <= 1'b1;
                    link_data <= pc_inc;
                end
                if (is_trap) begin
                    tt_req  <= 1'b1;
                    tt_addr <= vec_addr;
                end else begin
                    npc_valid <= 1'b1;
                    npc       <= target;
                end
            end else if (trap_done) begin
                npc_valid <= 1'b1;
                npc       <= tt_rdata;
            end
        end
    end

    AST_REQ_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        tt_req |-> (busy && link_we)); // R7
    AST_REQ_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
        tt_req |=> !tt_req); // R7
    AST_TABLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        tt_req |-> (tt_addr[XLEN-1:VEC_W] == '0)); // R7
    AST_NPC_FROM_TABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && tt_rvalid) |=> (npc_valid && npc == $past(tt_rdata))); // R8
    AST_NO_NPC_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        npc_valid |-> !busy); // R8
    AST_BUSY_IGNORES: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && instr_valid && !tt_rvalid) |=> (!npc_valid && !tt_req && !link_we)); // R9

endmodule

// File: tb/tb_npc_link_unit.sv
module tb_npc_link_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        instr_valid = 1'b0;
    logic [15:0] instr = '0, pc_inc = '0, base_val = '0, tt_rdata = '0;
    logic        br_taken = 1'b0, tt_rvalid = 1'b0;
    logic [2:0]  base_sel;
    logic        npc_valid, link_we, tt_req, busy;
    logic [15:0] npc, link_data, tt_addr;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    npc_link_unit dut (
        .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr(instr),
        .pc_inc(pc_inc), .base_val(base_val), .br_taken(br_taken),
        .tt_rdata(tt_rdata), .tt_rvalid(tt_rvalid), .base_sel(base_sel),
        .npc_valid(npc_valid), .npc(npc), .link_we(link_we), .link_data(link_data),
        .tt_req(tt_req), .tt_addr(tt_addr), .busy(busy)
    );

    // Behavioural reference model
    logic        m_valid, m_lwe, m_req, m_busy;
    logic [15:0] m_npc, m_ldata, m_addr;
    string       m_tag = "R1";

    function automatic logic [15:0] sx(input int v, input int bits);
        int s;
        s = v & ((1 << bits) - 1);
        if (s >= (1 << (bits - 1))) s = s - (1 << bits);
        return 16'(s);
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_valid <= 0; m_lwe <= 0; m_req <= 0; m_busy <= 0;
            m_npc <= 0; m_ldata <= 0; m_addr <= 0; m_tag <= "R1";
        end else begin
            m_valid <= 0; m_lwe <= 0; m_req <= 0;
            if (m_busy) begin
                if (tt_rvalid) begin
                    m_valid <= 1; m_npc <= tt_rdata; m_busy <= 0; m_tag <= "R8";
                end else if (instr_valid) m_tag <= "R9";
            end else if (instr_valid) begin
                case (instr[15:12])
                    4'h0: begin
                        m_valid <= 1;
                        m_npc <= br_taken ? pc_inc + sx(int'(instr), 9) : pc_inc;
                        m_tag <= br_taken ? "R2" : "R3";
                    end
                    4'h4: begin
                        m_valid <= 1; m_lwe <= 1; m_ldata <= pc_inc;
                        m_npc <= instr[11] ? pc_inc + sx(int'(instr), 11) : base_val;
                        m_tag <= instr[11] ? "R4" : "R5";
                    end
                    4'hC: begin
                        m_valid <= 1; m_npc <= base_val; m_tag <= "R6";
                    end
                    4'hF: begin
                        m_req <= 1; m_addr <= {8'h00, instr[7:0]};
                        m_lwe <= 1; m_ldata <= pc_inc; m_busy <= 1; m_tag <= "R7";
                    end
                    default: begin
                        m_valid <= 1; m_npc <= pc_inc; m_tag <= "R10";
                    end
                endcase
            end else if (tt_rvalid) m_tag <= "R9";
        end
    end

    task automatic cmp(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h at %0t", tag, what, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        #5;
        cmp(m_tag, "npc_valid", int'(npc_valid), int'(m_valid));
        cmp(m_tag, "npc", int'(npc), int'(m_npc));
        cmp(m_tag, "link_we", int'(link_we), int'(m_lwe));
        cmp(m_tag, "link_data", int'(link_data), int'(m_ldata));
        cmp(m_tag, "tt_req", int'(tt_req), int'(m_req));
        cmp(m_tag, "tt_addr", int'(tt_addr), int'(m_addr));
        cmp(m_tag, "busy", int'(busy), int'(m_busy));
        cmp("R6", "base_sel", int'(base_sel), int'(instr[8:6]));
    end

    task automatic issue(input logic [15:0] w, input logic [15:0] pc,
                         input logic [15:0] bv, input logic tk);
        @(negedge clk);
        instr = w; pc_inc = pc; base_val = bv; br_taken = tk; instr_valid = 1;
        @(negedge clk);
        instr_valid = 0;
    endtask

    // trap with response latency lat; junk instruction pulses during the wait
    task automatic trap(input logic [7:0] vec, input logic [15:0] pc,
                        input int lat, input logic [15:0] handler, input bit junk);
        @(negedge clk);
        instr = {4'hF, 4'h0, vec}; pc_inc = pc; instr_valid = 1;
        @(negedge clk);
        instr_valid = 0;
        for (int i = 0; i < lat; i++) begin
            instr = 16'h4800; pc_inc = pc + 16'h0100; instr_valid = junk;
            @(negedge clk);
        end
        instr_valid = 0;
        tt_rdata = handler; tt_rvalid = 1;
        @(negedge clk);
        tt_rvalid = 0; tt_rdata = 16'hDEAD;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        repeat (2) @(negedge clk);
        issue(16'h0E05, 16'h3001, 16'h0, 1);   // R2 forward
        issue(16'h0F00, 16'h3001, 16'h0, 1);   // R2 offset -256
        issue(16'h01FF, 16'h0000, 16'h0, 1);   // R2 wrap to FFFF
        issue(16'h0E05, 16'h3001, 16'h0, 0);   // R3
        issue(16'h4BFF, 16'h3000, 16'h0, 0);   // R4 +1023
        issue(16'h4C00, 16'h3000, 16'h0, 0);   // R4 -1024
        issue(16'h41C0, 16'h3010, 16'h5555, 0); // R5 call through R7: old value
        issue(16'h4080, 16'h3020, 16'h1234, 0); // R5 call through R2
        issue(16'hC1C0, 16'h4000, 16'h3011, 0); // R6 return
        issue(16'hC080, 16'h4000, 16'hABCD, 0); // R6 jump R2
        issue(16'h1261, 16'h3005, 16'h0, 1);   // R10
        trap(8'h25, 16'h3100, 0, 16'h0520, 0); // R7 R8 immediate response
        trap(8'h21, 16'h3200, 4, 16'h0430, 1); // R9 junk during wait
        trap(8'hFF, 16'hFFFF, 2, 16'hBEEF, 0);
        @(negedge clk); tt_rdata = 16'h7777; tt_rvalid = 1; // R9 stray response
        @(negedge clk); tt_rvalid = 0;
        for (int n = 0; n < 400; n++) begin
            int sel;
            sel = $urandom_range(0, 5);
            if (sel == 5)
                trap(8'($urandom), 16'($urandom), $urandom_range(0, 3), 16'($urandom), 1'($urandom));
            else begin
                logic [3:0] op;
                op = (sel == 0) ? 4'h0 : (sel == 1) ? 4'h4 : (sel == 2) ? 4'hC : 4'($urandom);
                if (op == 4'hF) op = 4'h5;
                issue({op, 12'($urandom)}, 16'($urandom), 16'($urandom), 1'($urandom));
            end
        end
        repeat (3) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule